// File: doc/BRIEF.md
# Reservation Monitor for Conditional Stores

This block sits beside one processor and lets it build atomic read-modify-write sequences without holding the shared bus. A load-reserved request sets a single reservation on the cache block that contains the load address, and asks memory for the word. A later store-conditional is forwarded to memory only when the reservation is still standing and covers the store address. Otherwise the store is dropped. The outcome is held in a status register that the processor reads.

While it holds a reservation, the monitor watches the store traffic from the other agents on the bus. A store to any word of the reserved block removes the reservation. A successful conditional store is also announced on a broadcast output, so that the monitors of other processors can drop their own reservations on that block. Several processors may hold a reservation on the same block at the same time. Only the first conditional store among them succeeds.

Top module: `resv_monitor`

## Requirements
- R1: After reset `resv_flag`, `sc_done` and `sc_pass` are 0, and `mem_we` and `bcast_valid` stay 0 while no request is made.
- R2: A load-reserved request (`lr_req`=1) raises `mem_rd_en` in the same cycle with `mem_addr` equal to `cpu_addr`, and sets `resv_flag` to 1 on the next clock edge.
- R3: A store-conditional (`sc_req`=1) with `resv_flag`=1 and `cpu_addr` in the reserved block succeeds. In that same cycle `mem_we`=1, `mem_addr`=`cpu_addr` and `mem_wdata`=`cpu_wdata`, and `bcast_valid`=1 with `bcast_addr`=`cpu_addr`.
- R4: A store-conditional without a reservation, or to a different block, keeps `mem_we` and `bcast_valid` at 0, so memory is left unchanged.
- R5: `sc_done` is 1 exactly in the cycle after a store-conditional. `sc_pass` gives its outcome from that cycle on (1 = success) and holds it until the next store-conditional.
- R6: Every store-conditional clears `resv_flag` on the next edge, whether it succeeds or fails.
- R7: The block is `cpu_addr` with its low `OFF_W` bits dropped (16-byte blocks by default). A valid snooped store on any snoop port to any byte of the reserved block clears `resv_flag`. A snooped store to another block leaves it set.
- R8: A new load-reserved request replaces the earlier reservation. Only the newest block can then be stored conditionally.
- R9: If a snooped store hits the reserved block in the same cycle as a store-conditional, the snooped store wins and the conditional store fails. If it arrives in the same cycle as a load-reserved request, the new reservation is kept.
- R10: When `lr_req` and `sc_req` are both 1, only the store-conditional acts: `mem_rd_en` stays 0 and `resv_flag` is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_req | input | 1 | Load-reserved request |
| sc_req | input | 1 | Store-conditional request |
| cpu_addr | input | ADDR_W | Byte address of the request |
| cpu_wdata | input | DATA_W | Store-conditional data |
| snp_valid | input | NUM_SNP | One bit per snoop port: a store by another agent |
| snp_addr | input | NUM_SNP*ADDR_W | Snooped store addresses, port 0 in the low bits |
| mem_rd_en | output | 1 | Memory read for a load-reserved request |
| mem_we | output | 1 | Forwarded memory write of a successful conditional store |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| bcast_valid | output | 1 | Announces a successful conditional store to other monitors |
| bcast_addr | output | ADDR_W | Address of the announced store |
| resv_flag | output | 1 | Reservation currently held |
| sc_done | output | 1 | One-cycle pulse after each store-conditional |
| sc_pass | output | 1 | Held outcome of the last store-conditional |

## Verification
The memory read, the forwarded write and the broadcast are combinational on the request, so they are due in the issue cycle. The bench checks them 1 ns after it drives the inputs on the falling edge. The reservation flag, `sc_done` and `sc_pass` come from registers and are due one edge later. The bench applies one idle cycle and samples them on the next falling edge. It also samples again after a further idle cycle to confirm that `sc_pass` holds. Memory contents are checked in a harness array that the bench owns.

// File: rtl/resv_pkg.sv
package resv_pkg;
    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_LOAD = 2'd1,
        REQ_COND = 2'd2
    } req_kind_e;

    function automatic req_kind_e decode_req(input logic lr, input logic sc);
        if (sc)      return REQ_COND;
        else if (lr) return REQ_LOAD;
        else         return REQ_NONE;
    endfunction
endpackage

// File: rtl/resv_block_cmp.sv
module resv_block_cmp #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4
) (
    input  logic                    en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [ADDR_W-OFF_W-1:0] tag,
    output logic                    hit
);
    localparam int TAG_W = ADDR_W - OFF_W;

    logic [TAG_W-1:0] addr_tag;

    always_comb begin
        addr_tag = addr[ADDR_W-1:OFF_W];
        hit      = en && (addr_tag == tag);
    end
endmodule

// File: rtl/resv_snoop.sv
module resv_snoop #(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 4,
    parameter int NUM_SNP = 2
) (
    input  logic [NUM_SNP-1:0]        snp_valid,
    input  logic [NUM_SNP*ADDR_W-1:0] snp_addr,
    input  logic [ADDR_W-OFF_W-1:0]   tag,
    output logic                      kill
);
    logic [NUM_SNP-1:0] port_hit;

    for (genvar g = 0; g < NUM_SNP; g++) begin : g_port
        resv_block_cmp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_cmp (
            .en   (snp_valid[g]),
            .addr (snp_addr[g*ADDR_W +: ADDR_W]),
            .tag  (tag),
            .hit  (port_hit[g])
        );
    end

    always_comb kill = |port_hit;
endmodule

// File: rtl/resv_state.sv
module resv_state #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  resv_pkg::req_kind_e     kind,
    input  logic [ADDR_W-OFF_W-1:0] new_tag,
    input  logic                    snoop_kill,
    output logic                    flag,
    output logic [ADDR_W-OFF_W-1:0] tag
);
    import resv_pkg::*;
    localparam int TAG_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic             flag;
        logic [TAG_W-1:0] tag;
    } resv_t;

    resv_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (kind)
            REQ_COND: st_d.flag = 1'b0;
            REQ_LOAD: begin
                st_d.flag = 1'b1;
                st_d.tag  = new_tag;
            end
            default: if (snoop_kill) st_d.flag = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        flag = st_q.flag;
        tag  = st_q.tag;
    end

    // R6
    cond_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kind == REQ_COND |=> !flag);
    // R2
    load_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kind == REQ_LOAD |=> flag && tag == $past(new_tag));
    // R7
    snoop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == REQ_NONE && snoop_kill) |=> !flag);
endmodule

// File: rtl/resv_status.sv
module resv_status (
    input  logic clk,
    input  logic rst_n,
    input  logic cond_req,
    input  logic cond_ok,
    output logic done,
    output logic pass
);
    typedef struct packed {
        logic done;
        logic pass;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = cond_req;
        if (cond_req) st_d.pass = cond_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        done = st_q.done;
        pass = st_q.pass;
    end

    // R5
    pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_req |=> $stable(pass) && !done);
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond_req |=> done && pass == $past(cond_ok));
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int OFF_W   = 4,
    parameter int NUM_SNP = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      lr_req,
    input  logic                      sc_req,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic [DATA_W-1:0]         cpu_wdata,
    input  logic [NUM_SNP-1:0]        snp_valid,
    input  logic [NUM_SNP*ADDR_W-1:0] snp_addr,
    output logic                      mem_rd_en,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [DATA_W-1:0]         mem_wdata,
    output logic                      bcast_valid,
    output logic [ADDR_W-1:0]         bcast_addr,
    output logic                      resv_flag,
    output logic                      sc_done,
    output logic                      sc_pass
);
    import resv_pkg::*;
    localparam int TAG_W = ADDR_W - OFF_W;

    req_kind_e        kind;
    logic [TAG_W-1:0] held_tag;
    logic             held_flag;
    logic             snoop_kill;
    logic             cpu_hit;
    logic             cond_ok;

    always_comb kind = decode_req(lr_req, sc_req);

    resv_snoop #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .NUM_SNP(NUM_SNP)) u_snoop (
        .snp_valid (snp_valid),
        .snp_addr  (snp_addr),
        .tag       (held_tag),
        .kill      (snoop_kill)
    );

    resv_block_cmp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_cpu_cmp (
        .en   (held_flag),
        .addr (cpu_addr),
        .tag  (held_tag),
        .hit  (cpu_hit)
    );

    resv_state #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .new_tag    (cpu_addr[ADDR_W-1:OFF_W]),
        .snoop_kill (snoop_kill),
        .flag       (held_flag),
        .tag        (held_tag)
    );

    always_comb begin
        cond_ok     = (kind == REQ_COND) && cpu_hit && !snoop_kill;
        mem_rd_en   = (kind == REQ_LOAD);
        mem_we      = cond_ok;
        mem_addr    = cpu_addr;
        mem_wdata   = cpu_wdata;
        bcast_valid = cond_ok;
        bcast_addr  = cpu_addr;
        resv_flag   = held_flag;
    end

    resv_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond_req (kind == REQ_COND),
        .cond_ok  (cond_ok),
        .done     (sc_done),
        .pass     (sc_pass)
    );

    // R4
    write_needs_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> resv_flag && sc_req);
    // R3
    write_broadcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> bcast_valid && bcast_addr == mem_addr);
    // R10
    cond_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |-> !mem_rd_en);
    // R5
    pass_means_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sc_pass) |-> $past(mem_we));
endmodule

// File: tb/tb_resv_monitor.sv
module tb_resv_monitor;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int NS = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lr_req = 1'b0, sc_req = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [NS-1:0] snp_valid = '0;
    logic [NS*AW-1:0] snp_addr = '0;
    logic          mem_rd_en, mem_we, bcast_valid, resv_flag, sc_done, sc_pass;
    logic [AW-1:0] mem_addr, bcast_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem [16];

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    resv_monitor #(.ADDR_W(AW), .DATA_W(DW), .OFF_W(4), .NUM_SNP(NS)) dut (
        .clk(clk), .rst_n(rst_n), .lr_req(lr_req), .sc_req(sc_req),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .snp_valid(snp_valid), .snp_addr(snp_addr),
        .mem_rd_en(mem_rd_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .bcast_valid(bcast_valid), .bcast_addr(bcast_addr),
        .resv_flag(resv_flag), .sc_done(sc_done), .sc_pass(sc_pass)
    );

    always @(posedge clk) if (mem_we) mem[mem_addr[5:2]] <= mem_wdata;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic lr, input logic sc, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic [NS-1:0] sv,
                         input logic [AW-1:0] s0, input logic [AW-1:0] s1);
        @(negedge clk);
        lr_req = lr; sc_req = sc; cpu_addr = a; cpu_wdata = d;
        snp_valid = sv; snp_addr = {s1, s0};
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, '0, '0, '0, '0, '0);
    endtask

    task automatic t_reset();
        idle();
        check("R1 flag", resv_flag, 0);
        check("R1 done", sc_done, 0);
        check("R1 pass", sc_pass, 0);
        check("R1 we", mem_we, 0);
        check("R1 bcast", bcast_valid, 0);
    endtask

    task automatic t_pass();
        drive(1, 0, 32'h10, 0, 0, 0, 0);
        check("R2 rd_en", mem_rd_en, 1);
        check("R2 addr", mem_addr, 32'h10);
        idle();
        check("R2 flag", resv_flag, 1);
        drive(0, 1, 32'h14, 32'hCAFE0001, 0, 0, 0);
        check("R3 we", mem_we, 1);
        check("R3 addr", mem_addr, 32'h14);
        check("R3 data", mem_wdata, 32'hCAFE0001);
        check("R3 bcast", bcast_valid, 1);
        check("R3 bcast_addr", bcast_addr, 32'h14);
        idle();
        check("R3 mem", mem[5], 32'hCAFE0001);
        check("R5 done", sc_done, 1);
        check("R5 pass", sc_pass, 1);
        check("R6 flag", resv_flag, 0);
        idle();
        check("R5 done drops", sc_done, 0);
        check("R5 pass holds", sc_pass, 1);
    endtask

    task automatic t_no_resv();
        drive(0, 1, 32'h10, 32'h1111, 0, 0, 0);
        check("R4 we", mem_we, 0);
        check("R4 bcast", bcast_valid, 0);
        idle();
        check("R4 mem", mem[4], 32'h0);
        check("R5 pass", sc_pass, 0);
        check("R5 done", sc_done, 1);
    endtask

    task automatic t_wrong_blk();
        drive(1, 0, 32'h10, 0, 0, 0, 0);
        drive(0, 1, 32'h20, 32'h2222, 0, 0, 0);
        check("R4 other block we", mem_we, 0);
        idle();
        check("R6 failed clears", resv_flag, 0);
        check("R4 mem", mem[8], 32'h0);
    endtask

    task automatic t_snoop();
        drive(1, 0, 32'h10, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 2'b10, 0, 32'h24);
        idle();
        check("R7 other block keeps", resv_flag, 1);
        drive(0, 0, 0, 0, 2'b01, 32'h1C, 0);
        idle();
        check("R7 same block clears", resv_flag, 0);
        drive(0, 1, 32'h10, 32'h3333, 0, 0, 0);
        check("R7 sc after snoop", mem_we, 0);
        idle();
    endtask

    task automatic t_replace();
        drive(1, 0, 32'h10, 0, 0, 0, 0);
        drive(1, 0, 32'h20, 0, 0, 0, 0);
        drive(0, 1, 32'h10, 32'h4444, 0, 0, 0);
        check("R8 old block fails", mem_we, 0);
        drive(1, 0, 32'h10, 0, 0, 0, 0);
        drive(1, 0, 32'h20, 0, 0, 0, 0);
        drive(0, 1, 32'h28, 32'h5555, 0, 0, 0);
        check("R8 new block passes", mem_we, 1);
        idle();
        check("R8 mem", mem[10], 32'h5555);
    endtask

    task automatic t_race();
        drive(1, 0, 32'h10, 0, 0, 0, 0);
        drive(0, 1, 32'h10, 32'h6666, 2'b10, 0, 32'h18);
        check("R9 snoop beats sc", mem_we, 0);
        idle();
        check("R9 pass", sc_pass, 0);
        drive(1, 0, 32'h10, 0, 2'b01, 32'h10, 0);
        idle();
        check("R9 lr kept", resv_flag, 1);
    endtask

    task automatic t_both();
        drive(1, 1, 32'h10, 32'h7777, 0, 0, 0);
        check("R10 sc acts", mem_we, 1);
        check("R10 no read", mem_rd_en, 0);
        idle();
        check("R10 flag", resv_flag, 0);
        check("R10 pass", sc_pass, 1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pass();
        t_no_resv();
        t_wrong_blk();
        t_snoop();
        t_replace();
        t_race();
        t_both();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule